// File: doc/BRIEF.md
# Parallel NOR Flash Command Interface

This block models a parallel NOR flash device whose array is altered only through command sequences written on a simple host bus. A small byte array, sized as a whole number of uniform erase sectors, holds the contents. A write-cycle state machine decodes the command bytes. It drives single-word programming, sector erase with a confirm step, buffered writes of several words, status clear, and lock commands. Lock commands are accepted but do not change the array.

Every bus access carries a fixed number of byte lanes, which is a parameter. The lanes are packed in little- or big-endian order, and a second parameter selects which. The command that is currently active decides what a read returns. It can be array data, the status register, the identification codes, or a byte from a built-in query table. A read-only input stops every change to the array. When that input is high, a program or erase attempt only sets error flags in the status register.

Top module: `nor_cmd_flash`

## Requirements
- R1: During reset the status register clears to 0, the array fills with 0xFF, the machine enters array-read mode and `rdata` clears to 0. Each `rd_en` cycle loads `rdata` on that clock edge.
- R2: In array-read mode a read returns LANES bytes starting at `addr`. The address wraps modulo the array size. With little-endian order, the byte at `addr` sits in bits 7:0.
- R3: A write of command 0x10 or 0x40 arms one program. The next write stores its data at its address and sets status bit 7. The machine then returns to array-read mode.
- R4: Command 0x20 fills the whole sector that holds the address with 0xFF and sets status bit 7. A following 0xD0 confirms and leaves status reads active. A following 0xFF, or any other byte, returns to array-read mode.
- R5: While `read_only` is high the array never changes. An erase attempt sets status bit 5 and a program data word sets status bit 4. Bit 7 is set in both cases.
- R6: Command 0xE8 sets bit 7. The next write gives a count N, and the N+1 writes after it store data words. A final 0xD0 confirms and leaves status reads active. Any other final byte returns to array-read mode.
- R7: While the active command is 0x20, 0x50, 0x60, 0x70 or 0xE8, reads return the status register in the low 8 bits.
- R8: Command 0x50 clears the whole status register and returns to array-read mode. Commands 0xFF and 0x00 return to array-read mode.
- R9: Commands 0x70 and 0x90 select status read and ID read without advancing the write cycle. The next write is therefore decoded as a fresh command.
- R10: In ID mode the index is `addr[7:0] >> log2(LANES)`. Index 0 returns {ID0,ID1}, index 1 returns {ID2,ID3}, and any other index returns 0.
- R11: Command 0x98 selects query mode, which uses the same index rule as ID mode. Bytes 0x51, 0x52, 0x59 ("QRY") sit at indices 0x10 to 0x12. Index 0x2A holds 8 when LANES is 1 and 11 otherwise. An index of 0x52 or above returns 0. Only 0xFF leaves query mode.
- R12: Command 0x60 followed by 0xD0 or 0x01 sets bit 7, leaves status reads active and leaves the array unchanged. Any other second byte returns to array-read mode.
- R13: An unrecognised first-cycle command returns to array-read mode and leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe; command byte is `wdata[7:0]` |
| rd_en | input | 1 | Bus read strobe; result appears on `rdata` after the edge |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8*LANES | Write data, command byte or word count |
| read_only | input | 1 | Blocks all array changes when high |
| rdata | output | 8*LANES | Registered read result |

## Verification
A wrong write-cycle state shows up on the very next read. The read steers to status, ID, query or array data, so a stale command turns an expected array word into a status byte, or the reverse. Corrupt array bytes or a wrong sector base appear as soon as the affected word is read back and compared with the bench's own byte model. A status bit that was lost or never cleared shows on the first status read after the sequence that should have changed it. A buffered write that miscounts shifts the confirm step, so the expected confirm either falls into the array or gets dropped, and a neighbouring word shows the damage.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;
  typedef enum logic [1:0] {WC_IDLE, WC_ARG, WC_DATA, WC_CONF} wcycle_t;

  localparam logic [7:0] OP_NONE     = 8'h00;
  localparam logic [7:0] OP_PROG_A   = 8'h10;
  localparam logic [7:0] OP_PROG_B   = 8'h40;
  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_CLRSR    = 8'h50;
  localparam logic [7:0] OP_LOCK     = 8'h60;
  localparam logic [7:0] OP_RDSR     = 8'h70;
  localparam logic [7:0] OP_RDID     = 8'h90;
  localparam logic [7:0] OP_QUERY    = 8'h98;
  localparam logic [7:0] OP_BUFWR    = 8'hE8;
  localparam logic [7:0] OP_ARRAY    = 8'hFF;
  localparam logic [7:0] OP_CONFIRM  = 8'hD0;
  localparam logic [7:0] OP_LOCK_ALT = 8'h01;

  localparam int SR_READY     = 7;
  localparam int SR_ERASE_ERR = 5;
  localparam int SR_PROG_ERR  = 4;

  localparam int QUERY_LEN = 'h52;
endpackage

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_flash_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          ro,
  output logic [7:0]    cmd_q,
  output logic [7:0]    status_q,
  output logic          prog_o,
  output logic          erase_o
);
  wcycle_t       wc_q, wc_d;
  logic [7:0]    cmd_d, status_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic [7:0]    wbyte;
  logic          go_idle;

  assign wbyte = wdata[7:0];

  always_comb begin
    wc_d     = wc_q;
    cmd_d    = cmd_q;
    status_d = status_q;
    cnt_d    = cnt_q;
    prog_o   = 1'b0;
    erase_o  = 1'b0;
    go_idle  = 1'b0;
    if (wr_en) begin
      case (wc_q)
        WC_IDLE: begin
          case (wbyte)
            OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
              wc_d  = WC_ARG;
              cmd_d = wbyte;
            end
            OP_ERASE: begin
              erase_o = !ro;
              if (ro) status_d[SR_ERASE_ERR] = 1'b1;
              status_d[SR_READY] = 1'b1;
              wc_d  = WC_ARG;
              cmd_d = wbyte;
            end
            OP_CLRSR: begin
              status_d = '0;
              go_idle  = 1'b1;
            end
            OP_RDSR, OP_RDID: cmd_d = wbyte;
            OP_BUFWR: begin
              status_d[SR_READY] = 1'b1;
              wc_d  = WC_ARG;
              cmd_d = wbyte;
            end
            default: go_idle = 1'b1;
          endcase
        end
        WC_ARG: begin
          case (cmd_q)
            OP_PROG_A, OP_PROG_B: begin
              prog_o = !ro;
              if (ro) status_d[SR_PROG_ERR] = 1'b1;
              status_d[SR_READY] = 1'b1;
              wc_d  = WC_IDLE;
              cmd_d = OP_NONE;
            end
            OP_ERASE, OP_LOCK: begin
              if (wbyte == OP_CONFIRM || (cmd_q == OP_LOCK && wbyte == OP_LOCK_ALT)) begin
                wc_d = WC_IDLE;
                status_d[SR_READY] = 1'b1;
              end else begin
                go_idle = 1'b1;
              end
            end
            OP_BUFWR: begin
              cnt_d = wdata;
              wc_d  = WC_DATA;
            end
            OP_QUERY: if (wbyte == OP_ARRAY) go_idle = 1'b1;
            default: go_idle = 1'b1;
          endcase
        end
        WC_DATA: begin
          prog_o = !ro;
          if (ro) status_d[SR_PROG_ERR] = 1'b1;
          status_d[SR_READY] = 1'b1;
          if (cnt_q == '0) wc_d = WC_CONF;
          cnt_d = cnt_q - 1'b1;
        end
        default: begin
          if (wbyte == OP_CONFIRM) begin
            wc_d = WC_IDLE;
            status_d[SR_READY] = 1'b1;
          end else begin
            go_idle = 1'b1;
          end
        end
      endcase
      if (go_idle) begin
        wc_d  = WC_IDLE;
        cmd_d = OP_NONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wc_q     <= WC_IDLE;
      cmd_q    <= OP_NONE;
      status_q <= '0;
      cnt_q    <= '0;
    end else begin
      wc_q     <= wc_d;
      cmd_q    <= cmd_d;
      status_q <= status_d;
      cnt_q    <= cnt_d;
    end
  end

  // R9
  rdsr_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wc_q == WC_IDLE && (wbyte == OP_RDSR || wbyte == OP_RDID))
      |=> (wc_q == WC_IDLE && cmd_q == $past(wbyte)));

  // R6
  conf_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wc_q == WC_CONF) |-> $past(wc_q) == WC_DATA);

  // R3
  ready_after_prog_chk: assert property (@(posedge clk) disable iff (rst)
    prog_o |=> status_q[SR_READY]);

  // R5
  erase_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wc_q == WC_IDLE && wbyte == OP_ERASE && ro) |=> status_q[SR_ERASE_ERR]);
endmodule

// File: rtl/nor_byte_array.sv
module nor_byte_array #(
  parameter int TOTAL      = 256,
  parameter int SECT_BYTES = 32,
  parameter int LANES      = 2,
  parameter bit BIG_END    = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          prog_i,
  input  logic                          erase_i,
  input  logic [$clog2(TOTAL)-1:0]      addr_i,
  input  logic [8*LANES-1:0]            wdata_i,
  output logic [8*LANES-1:0]            rword_o
);
  localparam int AW = $clog2(TOTAL);
  localparam int SW = $clog2(SECT_BYTES);

  logic [8*TOTAL-1:0] flat;

  function automatic int lane_of(input int k);
    return BIG_END ? (LANES - 1 - k) : k;
  endfunction

  for (genvar b = 0; b < TOTAL; b++) begin : g_byte
    localparam logic [AW-1:0] BI = AW'(b);
    logic [7:0] cell_q;
    logic       hit;
    logic [7:0] lane_byte;

    always_comb begin
      hit       = 1'b0;
      lane_byte = 8'hFF;
      for (int k = 0; k < LANES; k++) begin
        if (AW'(addr_i + AW'(k)) == BI) begin
          hit       = 1'b1;
          lane_byte = wdata_i[8*lane_of(k) +: 8];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst)
        cell_q <= 8'hFF;
      else if (erase_i && addr_i[AW-1:SW] == BI[AW-1:SW])
        cell_q <= 8'hFF;
      else if (prog_i && hit)
        cell_q <= lane_byte;
    end

    assign flat[8*b +: 8] = cell_q;
  end

  always_comb begin
    rword_o = '0;
    for (int k = 0; k < LANES; k++) begin
      rword_o[8*lane_of(k) +: 8] = flat[8*int'(AW'(addr_i + AW'(k))) +: 8];
    end
  end

  // R4
  one_op_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_i, erase_i}));
endmodule

// File: rtl/nor_query_rom.sv
module nor_query_rom #(
  parameter int LANES      = 2,
  parameter int NUM_SECT   = 8,
  parameter int SECT_BYTES = 32
) (
  input  logic [7:0] idx_i,
  output logic [7:0] qbyte_o
);
  localparam int TOT_LOG = $clog2(NUM_SECT * SECT_BYTES);
  localparam int BUF_LOG = (LANES == 1) ? 8 : 11;

  always_comb begin
    case (idx_i)
      8'h10: qbyte_o = 8'h51;
      8'h11: qbyte_o = 8'h52;
      8'h12: qbyte_o = 8'h59;
      8'h13: qbyte_o = 8'h01;
      8'h15: qbyte_o = 8'h31;
      8'h1B: qbyte_o = 8'h45;
      8'h1C: qbyte_o = 8'h55;
      8'h1F, 8'h20: qbyte_o = 8'h07;
      8'h21: qbyte_o = 8'h0A;
      8'h23, 8'h24, 8'h25: qbyte_o = 8'h04;
      8'h27: qbyte_o = 8'(TOT_LOG);
      8'h28: qbyte_o = 8'h02;
      8'h2A: qbyte_o = 8'(BUF_LOG);
      8'h2C: qbyte_o = 8'h01;
      8'h2D: qbyte_o = 8'(NUM_SECT - 1);
      8'h2E: qbyte_o = 8'((NUM_SECT - 1) >> 8);
      8'h2F: qbyte_o = 8'(SECT_BYTES >> 8);
      8'h30: qbyte_o = 8'(SECT_BYTES >> 16);
      8'h31: qbyte_o = 8'h50;
      8'h32: qbyte_o = 8'h52;
      8'h33: qbyte_o = 8'h49;
      8'h34: qbyte_o = 8'h31;
      8'h35: qbyte_o = 8'h30;
      8'h3F: qbyte_o = 8'h01;
      default: qbyte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash
  import nor_flash_pkg::*;
#(
  parameter int       ADDR_W     = 8,
  parameter int       LANES      = 2,
  parameter int       NUM_SECT   = 8,
  parameter int       SECT_BYTES = 32,
  parameter bit       BIG_END    = 1'b0,
  parameter bit [7:0] ID0        = 8'h89,
  parameter bit [7:0] ID1        = 8'h01,
  parameter bit [7:0] ID2        = 8'h88,
  parameter bit [7:0] ID3        = 8'h17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [8*LANES-1:0] wdata,
  input  logic              read_only,
  output logic [8*LANES-1:0] rdata
);
  localparam int DW     = 8 * LANES;
  localparam int TOTAL  = NUM_SECT * SECT_BYTES;
  localparam int AW     = $clog2(TOTAL);
  localparam int IDX_SH = $clog2(LANES);

  logic [7:0]    cmd, status, qbyte, idx;
  logic          prog, erase;
  logic [DW-1:0] arr_word, rd_next;

  assign idx = addr[7:0] >> IDX_SH;

  nor_cmd_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .ro(read_only),
    .cmd_q(cmd), .status_q(status), .prog_o(prog), .erase_o(erase)
  );

  nor_byte_array #(.TOTAL(TOTAL), .SECT_BYTES(SECT_BYTES), .LANES(LANES), .BIG_END(BIG_END)) u_arr (
    .clk(clk), .rst(rst), .prog_i(prog), .erase_i(erase),
    .addr_i(addr[AW-1:0]), .wdata_i(wdata), .rword_o(arr_word)
  );

  nor_query_rom #(.LANES(LANES), .NUM_SECT(NUM_SECT), .SECT_BYTES(SECT_BYTES)) u_rom (
    .idx_i(idx), .qbyte_o(qbyte)
  );

  always_comb begin
    case (cmd)
      OP_NONE: rd_next = arr_word;
      OP_ERASE, OP_CLRSR, OP_LOCK, OP_RDSR, OP_BUFWR: rd_next = DW'(status);
      OP_RDID: begin
        if (idx == 8'd0)      rd_next = DW'({ID0, ID1});
        else if (idx == 8'd1) rd_next = DW'({ID2, ID3});
        else                  rd_next = '0;
      end
      OP_QUERY: rd_next = (int'(idx) < QUERY_LEN) ? DW'(qbyte) : '0;
      default: rd_next = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  // R1
  reset_rdata_chk: assert property (@(posedge clk) $fell(rst) |-> rdata == '0);

  // R11
  qry_range_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cmd == OP_QUERY && int'(idx) >= QUERY_LEN) |=> rdata == '0);
endmodule

// File: tb/nor_cmd_flash_tb.sv
module nor_cmd_flash_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, read_only = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  int checks = 0, fails = 0;
  logic [7:0] ref_mem [256];

  // {opcode, address, data}
  localparam logic [31:0] PROG_VEC [4] = '{32'h10_10_A1B2, 32'h40_22_1234,
                                           32'h10_41_BEEF, 32'h40_FF_5A6B};

  always #4 clk = ~clk;

  nor_cmd_flash u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .read_only(read_only), .rdata(rdata)
  );

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  function automatic logic [15:0] ref_word(input logic [7:0] a);
    return {ref_mem[8'(a + 8'd1)], ref_mem[a]};
  endfunction

  task automatic ref_prog(input logic [7:0] a, input logic [15:0] d);
    ref_mem[a] = d[7:0];
    ref_mem[8'(a + 8'd1)] = d[15:8];
  endtask

  task automatic ref_erase(input logic [7:0] a);
    for (int i = 0; i < 32; i++) ref_mem[{a[7:5], 5'(i)}] = 8'hFF;
  endtask

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 rdata after reset", rdata, 16'h0000);
    rchk("R1 array erased", 8'h00, 16'hFFFF);
    wr(8'h00, 16'h0070);
    rchk("R1 status zero", 8'h00, 16'h0000);
    wr(8'h00, 16'h00FF);

    // R3 R2 program table
    for (int n = 0; n < 4; n++) begin
      wr(PROG_VEC[n][23:16], {8'h00, PROG_VEC[n][31:24]});
      wr(PROG_VEC[n][23:16], PROG_VEC[n][15:0]);
      ref_prog(PROG_VEC[n][23:16], PROG_VEC[n][15:0]);
      rchk("R3 program readback", PROG_VEC[n][23:16], ref_word(PROG_VEC[n][23:16]));
      wr(8'h00, 16'h0070);
      rchk("R3 ready bit", 8'h00, 16'h0080);
      wr(8'h00, 16'h00FF);
    end
    rchk("R2 unaligned little-endian", 8'h11, ref_word(8'h11));
    rchk("R2 wrap", 8'hFF, 16'h5A6B);

    // R9 status select then fresh command
    wr(8'h00, 16'h0070);
    wr(8'h30, 16'h0040);
    wr(8'h30, 16'hCAFE);
    ref_prog(8'h30, 16'hCAFE);
    rchk("R9 fresh command after status select", 8'h30, 16'hCAFE);

    // R4 R7 erase
    wr(8'h45, 16'h0020);
    ref_erase(8'h45);
    rchk("R7 status while erase active", 8'h00, 16'h0080);
    wr(8'h00, 16'h00D0);
    rchk("R4 status after confirm", 8'h00, 16'h0080);
    wr(8'h00, 16'h00FF);
    rchk("R4 sector filled", 8'h41, ref_word(8'h41));
    rchk("R4 other sector kept", 8'h10, ref_word(8'h10));
    wr(8'h30, 16'h0020);
    ref_erase(8'h30);
    wr(8'h00, 16'h0033);
    rchk("R4 bad confirm to array mode", 8'h30, 16'hFFFF);

    // R8 clear status
    wr(8'h00, 16'h0050);
    wr(8'h00, 16'h0070);
    rchk("R8 status cleared", 8'h00, 16'h0000);
    wr(8'h00, 16'h0000);
    rchk("R8 0x00 array mode", 8'h10, 16'hA1B2);

    // R5 read-only
    read_only = 1'b1;
    wr(8'h10, 16'h0010);
    wr(8'h10, 16'h7777);
    wr(8'h00, 16'h0070);
    rchk("R5 program error bit", 8'h00, 16'h0090);
    wr(8'h00, 16'h00FF);
    rchk("R5 program blocked", 8'h10, 16'hA1B2);
    wr(8'h10, 16'h0020);
    rchk("R5 erase error bit", 8'h00, 16'h00B0);
    wr(8'h00, 16'h00D0);
    wr(8'h00, 16'h00FF);
    rchk("R5 erase blocked", 8'h10, 16'hA1B2);
    read_only = 1'b0;
    wr(8'h00, 16'h0050);

    // R6 buffered write
    wr(8'h00, 16'h00E8);
    rchk("R7 status while buffer active", 8'h00, 16'h0080);
    wr(8'h00, 16'h0002);
    wr(8'h80, 16'h1111);
    wr(8'h82, 16'h2222);
    wr(8'h84, 16'h3333);
    wr(8'h00, 16'h00D0);
    rchk("R6 status after confirm", 8'h00, 16'h0080);
    wr(8'h00, 16'h00FF);
    rchk("R6 word 0", 8'h80, 16'h1111);
    rchk("R6 word 1", 8'h82, 16'h2222);
    rchk("R6 word 2", 8'h84, 16'h3333);
    wr(8'h00, 16'h00E8);
    wr(8'h00, 16'h0000);
    wr(8'h90, 16'h4444);
    wr(8'h92, 16'h0055);
    rchk("R6 N=0 single word, bad confirm", 8'h90, 16'h4444);
    rchk("R6 confirm byte not stored", 8'h92, 16'hFFFF);

    // R10 ID
    wr(8'h00, 16'h0090);
    rchk("R10 index 0", 8'h00, 16'h8901);
    rchk("R10 index 1", 8'h02, 16'h8817);
    rchk("R10 index 2", 8'h04, 16'h0000);
    wr(8'h00, 16'h00FF);

    // R11 query
    wr(8'h00, 16'h0098);
    rchk("R11 Q", 8'h20, 16'h0051);
    rchk("R11 R", 8'h22, 16'h0052);
    rchk("R11 Y", 8'h24, 16'h0059);
    rchk("R11 buffer size code", 8'h54, 16'h000B);
    rchk("R11 beyond table", 8'hA4, 16'h0000);
    wr(8'h00, 16'h0010);
    rchk("R11 stays in query", 8'h20, 16'h0051);
    wr(8'h00, 16'h00FF);
    rchk("R11 exit to array", 8'h10, 16'hA1B2);

    // R12 lock
    wr(8'h10, 16'h0060);
    wr(8'h10, 16'h0001);
    rchk("R12 status after 0x01", 8'h10, 16'h0080);
    wr(8'h00, 16'h00FF);
    rchk("R12 array unchanged", 8'h10, 16'hA1B2);
    wr(8'h10, 16'h0060);
    wr(8'h10, 16'h00D0);
    rchk("R12 status after 0xD0", 8'h10, 16'h0080);
    wr(8'h00, 16'h00FF);
    wr(8'h10, 16'h0060);
    wr(8'h10, 16'h0042);
    rchk("R12 other byte to array", 8'h10, 16'hA1B2);

    // R13 unknown command
    wr(8'h00, 16'h0070);
    wr(8'h00, 16'h0033);
    rchk("R13 array mode", 8'h10, 16'hA1B2);
    wr(8'h00, 16'h0070);
    rchk("R13 status unchanged", 8'h00, 16'h0080);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule